// File: doc/BRIEF.md
# Diagnostic Test Register File

This block is a 32-bit memory-mapped register slave that occupies the lowest diagnostic window of a device's register space. Driver authors use it to bring up and troubleshoot a new part. It provides four facilities. The first is a trap region that a correct driver never touches. The second is a pair of echo registers that return twice the value last written, which proves that host reads and writes reach the device intact. The third is a register that raises an interrupt request for any vector that software names. The fourth is a small engine that walks a host buffer one byte at a time and zeroes it, fills it with a fixed pattern, or complements it in place.

The host side is a single-beat register port with one request per cycle. A read returns its data one cycle after the request. Registers that are 64 bits wide appear as two 32-bit words at consecutive offsets, with the lower word at the lower address. The buffer engine drives a byte-wide memory master port. That port accepts one request per cycle and returns read data in the cycle after a read request. Interrupts leave the block as a one-cycle valid pulse that carries an 8-bit vector number, and a separate message generator turns that pulse into a real interrupt.

Top module: `diag_regfile`

## Requirements
- R1: Byte offsets 0x000 to 0x00F form a trap window. Every read there returns 0xDEADBABE, and writes there change no register.
- R2: The word at 0x010 holds a 32-bit value. A read returns that value multiplied by two, modulo 2^32.
- R3: The 64-bit echo value has its low word at 0x018 and its high word at 0x01C. A write to the low word is only staged. The following write to the high word commits {high, staged low} as one value. A read of either word returns the matching half of the committed value times two, modulo 2^64.
- R4: A write to 0x020 produces irq_valid high for exactly the next cycle, with irq_vec equal to bits [7:0] of the write data. A read of 0x020 returns the last vector in bits [7:0].
- R5: The buffer base address occupies 0x028 (low word) and 0x02C (high word), and the buffer size in bytes occupies 0x030. Each of these reads back as written.
- R6: The control word is at 0x034. A write of exactly 1 starts a clear (every byte becomes 0x00). A write of exactly 2 starts a fill (every byte becomes 0x96). A write of exactly 4 starts an invert (every byte becomes its bitwise complement). Any other value starts nothing and leaves the control word unchanged.
- R7: An operation touches exactly size bytes, in ascending order from the base address, and the base may be any byte address. Clear and fill take one memory write per byte. Invert takes a read followed by a write to the same address. Bytes outside the buffer are left unchanged.
- R8: A start with size 0 is accepted, with the code recorded in the control word, and it completes at once without any memory request.
- R9: A control read returns the busy flag in bit 31 and the last accepted code in bits [2:0]. A control write that arrives while busy is ignored.
- R10: Every other offset reads as 0 and ignores writes.
- R11: After reset all registers are zero, and rsp_valid, irq_valid and mem_valid are low. A read request produces rsp_valid with its data in the next cycle, least significant byte in bits [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read request |
| rsp_rdata | output | 32 | Read data |
| irq_valid | output | 1 | One-cycle interrupt request pulse |
| irq_vec | output | 8 | Vector number carried by the pulse |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | 1 = byte write, 0 = byte read |
| mem_addr | output | MEM_AW | Byte address |
| mem_wdata | output | 8 | Byte write data |
| mem_rdata | input | 8 | Byte read data, valid the cycle after a read request |

## Verification
The buffer engine runs on its own for many cycles after a start, so register traffic and an engine pass can overlap. The bench starts a 16-byte fill and, while the engine is still writing, issues a clear command, reads the control word, writes the echo register and fires an interrupt. The clear command must leave no trace, and the control read must show busy together with the fill code. The interrupt pulse and the echo value must match what they would be on an idle block. At the end every byte of the buffer must hold the fill pattern, and the memory access count must be 16.

// File: rtl/diag_pkg.sv
package diag_pkg;

    localparam logic [31:0] TRAP_MARK = 32'hDEADBABE;
    localparam logic [7:0]  FILL_BYTE = 8'h96;

    // byte offsets inside the diagnostic window
    localparam int OFS_ECHO32    = 'h010;
    localparam int OFS_ECHO64_LO = 'h018;
    localparam int OFS_ECHO64_HI = 'h01C;
    localparam int OFS_IRQ       = 'h020;
    localparam int OFS_BASE_LO   = 'h028;
    localparam int OFS_BASE_HI   = 'h02C;
    localparam int OFS_SIZE      = 'h030;
    localparam int OFS_CTRL      = 'h034;
    localparam int TRAP_END      = 'h010;

    // operation codes written to the control word
    localparam logic [2:0] OP_CLEAR  = 3'd1;
    localparam logic [2:0] OP_FILL   = 3'd2;
    localparam logic [2:0] OP_INVERT = 3'd4;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_PUT,
        ENG_GET,
        ENG_FLIP
    } eng_st_e;

    typedef struct packed {
        logic [31:0] echo32;
        logic [63:0] echo64;
        logic [31:0] stage64;
        logic [7:0]  irq_vec;
        logic        irq_valid;
        logic [63:0] base;
        logic [31:0] size;
        logic [2:0]  op;
        logic        rsp_valid;
        logic [31:0] rdata;
    } regs_t;

endpackage

// File: rtl/diag_buf_engine.sv
module diag_buf_engine
    import diag_pkg::*;
#(
    parameter int MEM_AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        op_i,
    input  logic [MEM_AW-1:0] base_i,
    input  logic [31:0]       size_i,
    output logic              busy_o,
    output logic              mem_valid_o,
    output logic              mem_write_o,
    output logic [MEM_AW-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    input  logic [7:0]        mem_rdata_i
);

    typedef struct packed {
        eng_st_e           st;
        logic [2:0]        op;
        logic [MEM_AW-1:0] ptr;
        logic [31:0]       left;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d       = eng_q;
        mem_valid_o = 1'b0;
        mem_write_o = 1'b0;
        mem_wdata_o = 8'h00;
        case (eng_q.st)
            ENG_IDLE: begin
                if (start_i && size_i != 32'd0) begin
                    eng_d.op   = op_i;
                    eng_d.ptr  = base_i;
                    eng_d.left = size_i;
                    eng_d.st   = (op_i == OP_INVERT) ? ENG_GET : ENG_PUT;
                end
            end
            ENG_PUT: begin
                mem_valid_o = 1'b1;
                mem_write_o = 1'b1;
                mem_wdata_o = (eng_q.op == OP_FILL) ? FILL_BYTE : 8'h00;
                eng_d.ptr   = eng_q.ptr + MEM_AW'(1);
                eng_d.left  = eng_q.left - 32'd1;
                if (eng_q.left == 32'd1) eng_d.st = ENG_IDLE;
            end
            ENG_GET: begin
                mem_valid_o = 1'b1;
                eng_d.st    = ENG_FLIP;
            end
            ENG_FLIP: begin
                mem_valid_o = 1'b1;
                mem_write_o = 1'b1;
                mem_wdata_o = ~mem_rdata_i;
                eng_d.ptr   = eng_q.ptr + MEM_AW'(1);
                eng_d.left  = eng_q.left - 32'd1;
                eng_d.st    = (eng_q.left == 32'd1) ? ENG_IDLE : ENG_GET;
            end
            default: eng_d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_q <= '{st: ENG_IDLE, op: 3'd0, ptr: '0, left: 32'd0};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign mem_addr_o = eng_q.ptr;
    assign busy_o     = (eng_q.st != ENG_IDLE);

    // R8: an empty buffer never makes the engine busy
    p_zero_size_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && size_i == 32'd0) |=> !busy_o);

    // R9: a start seen while busy does not disturb the running operation
    p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(eng_q.op));

    // R7: an invert write always follows a read of the same byte
    p_flip_after_get_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o && mem_write_o && eng_q.op == OP_INVERT) |->
        ($past(mem_valid_o && !mem_write_o) && $past(mem_addr_o) == mem_addr_o));

    // R7: consecutive write passes move up by exactly one byte
    p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o && mem_write_o && eng_q.op != OP_INVERT) |=>
        (!busy_o || mem_addr_o == $past(mem_addr_o) + MEM_AW'(1)));

endmodule

// File: rtl/diag_regs.sv
module diag_regs
    import diag_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int MEM_AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid_o,
    output logic [31:0]       rsp_rdata_o,
    output logic              irq_valid_o,
    output logic [7:0]        irq_vec_o,
    input  logic              eng_busy_i,
    output logic              eng_start_o,
    output logic [2:0]        eng_op_o,
    output logic [MEM_AW-1:0] eng_base_o,
    output logic [31:0]       eng_size_o
);

    localparam logic [ADDR_W-1:0] A_ECHO32    = ADDR_W'(OFS_ECHO32);
    localparam logic [ADDR_W-1:0] A_ECHO64_LO = ADDR_W'(OFS_ECHO64_LO);
    localparam logic [ADDR_W-1:0] A_ECHO64_HI = ADDR_W'(OFS_ECHO64_HI);
    localparam logic [ADDR_W-1:0] A_IRQ       = ADDR_W'(OFS_IRQ);
    localparam logic [ADDR_W-1:0] A_BASE_LO   = ADDR_W'(OFS_BASE_LO);
    localparam logic [ADDR_W-1:0] A_BASE_HI   = ADDR_W'(OFS_BASE_HI);
    localparam logic [ADDR_W-1:0] A_SIZE      = ADDR_W'(OFS_SIZE);
    localparam logic [ADDR_W-1:0] A_CTRL      = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_TRAP_END  = ADDR_W'(TRAP_END);

    regs_t regs_d, regs_q;

    logic [ADDR_W-1:0] word;
    logic              in_trap;
    logic              code_ok;
    logic [63:0]       dbl64;
    logic [31:0]       rd_mux;

    assign word    = req_addr & ~ADDR_W'(3);
    assign in_trap = (word < A_TRAP_END);
    assign code_ok = (req_wdata == {29'd0, OP_CLEAR}) ||
                     (req_wdata == {29'd0, OP_FILL})  ||
                     (req_wdata == {29'd0, OP_INVERT});
    assign dbl64   = regs_q.echo64 << 1;

    always_comb begin
        rd_mux = 32'd0;
        if (in_trap) begin
            rd_mux = TRAP_MARK;
        end else begin
            case (word)
                A_ECHO32:    rd_mux = regs_q.echo32 << 1;
                A_ECHO64_LO: rd_mux = dbl64[31:0];
                A_ECHO64_HI: rd_mux = dbl64[63:32];
                A_IRQ:       rd_mux = {24'd0, regs_q.irq_vec};
                A_BASE_LO:   rd_mux = regs_q.base[31:0];
                A_BASE_HI:   rd_mux = regs_q.base[63:32];
                A_SIZE:      rd_mux = regs_q.size;
                A_CTRL:      rd_mux = {eng_busy_i, 28'd0, regs_q.op};
                default:     rd_mux = 32'd0;
            endcase
        end
    end

    always_comb begin
        regs_d           = regs_q;
        regs_d.irq_valid = 1'b0;
        regs_d.rsp_valid = 1'b0;
        eng_start_o      = 1'b0;
        if (req_valid && req_write && !in_trap) begin
            case (word)
                A_ECHO32:    regs_d.echo32  = req_wdata;
                A_ECHO64_LO: regs_d.stage64 = req_wdata;
                A_ECHO64_HI: regs_d.echo64  = {req_wdata, regs_q.stage64};
                A_IRQ: begin
                    regs_d.irq_vec   = req_wdata[7:0];
                    regs_d.irq_valid = 1'b1;
                end
                A_BASE_LO:   regs_d.base[31:0]  = req_wdata;
                A_BASE_HI:   regs_d.base[63:32] = req_wdata;
                A_SIZE:      regs_d.size        = req_wdata;
                A_CTRL: begin
                    if (!eng_busy_i && code_ok) begin
                        regs_d.op   = req_wdata[2:0];
                        eng_start_o = 1'b1;
                    end
                end
                default: ;
            endcase
        end
        if (req_valid && !req_write) begin
            regs_d.rsp_valid = 1'b1;
            regs_d.rdata     = rd_mux;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rsp_valid_o = regs_q.rsp_valid;
    assign rsp_rdata_o = regs_q.rdata;
    assign irq_valid_o = regs_q.irq_valid;
    assign irq_vec_o   = regs_q.irq_vec;
    assign eng_op_o    = req_wdata[2:0];
    assign eng_base_o  = regs_q.base[MEM_AW-1:0];
    assign eng_size_o  = regs_q.size;

    // R1: a read inside the trap window answers with the marker
    p_trap_mark_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && $past(req_valid && !req_write && in_trap)) |->
        rsp_rdata_o == TRAP_MARK);

    // R4: each pulse comes from an interrupt-register write one cycle earlier
    p_irq_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |-> ($past(req_valid && req_write && word == A_IRQ) &&
                         irq_vec_o == $past(req_wdata[7:0])));

    // R11: read data appears only for a read request one cycle earlier
    p_rsp_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> $past(req_valid && !req_write));

    // R9: the engine is never started while it is busy
    p_start_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start_o |-> !eng_busy_i);

endmodule

// File: rtl/diag_regfile.sv
module diag_regfile
    import diag_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int MEM_AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              irq_valid,
    output logic [7:0]        irq_vec,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);

    logic              eng_busy;
    logic              eng_start;
    logic [2:0]        eng_op;
    logic [MEM_AW-1:0] eng_base;
    logic [31:0]       eng_size;

    diag_regs #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .rsp_valid_o (rsp_valid),
        .rsp_rdata_o (rsp_rdata),
        .irq_valid_o (irq_valid),
        .irq_vec_o   (irq_vec),
        .eng_busy_i  (eng_busy),
        .eng_start_o (eng_start),
        .eng_op_o    (eng_op),
        .eng_base_o  (eng_base),
        .eng_size_o  (eng_size)
    );

    diag_buf_engine #(.MEM_AW(MEM_AW)) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (eng_start),
        .op_i        (eng_op),
        .base_i      (eng_base),
        .size_i      (eng_size),
        .busy_o      (eng_busy),
        .mem_valid_o (mem_valid),
        .mem_write_o (mem_write),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_rdata_i (mem_rdata)
    );

endmodule

// File: tb/diag_regfile_bench.sv
module diag_regfile_bench;

    localparam int ADDR_W = 12;
    localparam int MEM_AW = 16;
    localparam int N_ROWS = 29;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid;
    logic [31:0]       rsp_rdata;
    logic              irq_valid;
    logic [7:0]        irq_vec;
    logic              mem_valid;
    logic              mem_write;
    logic [MEM_AW-1:0] mem_addr;
    logic [7:0]        mem_wdata;
    logic [7:0]        mem_rdata = 8'h00;

    logic [7:0] mem [256];
    int         acc_cnt = 0;
    int         total = 0;
    int         bad = 0;

    always #5 clk = ~clk;

    diag_regfile #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u_diag_regfile (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .irq_valid(irq_valid), .irq_vec(irq_vec),
        .mem_valid(mem_valid), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // behavioural host memory: each byte preset to its own index during reset
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i);
        end else if (mem_valid) begin
            if (mem_write) mem[mem_addr[7:0]] <= mem_wdata;
            else           mem_rdata <= mem[mem_addr[7:0]];
            acc_cnt <= acc_cnt + 1;
        end
    end

    // {tag, write, offset, wdata, expected read}
    localparam logic [80:0] ROWS [N_ROWS] = '{
        {4'd1,  1'b1, 12'h000, 32'h12345678, 32'h0},        // R1 write to trap
        {4'd1,  1'b0, 12'h000, 32'h0, 32'hDEADBABE},        // R1
        {4'd1,  1'b0, 12'h00C, 32'h0, 32'hDEADBABE},        // R1
        {4'd2,  1'b1, 12'h010, 32'd5, 32'h0},               // R2
        {4'd2,  1'b0, 12'h010, 32'h0, 32'h0000000A},        // R2
        {4'd2,  1'b1, 12'h010, 32'h80000003, 32'h0},        // R2 wrap
        {4'd2,  1'b0, 12'h010, 32'h0, 32'h00000006},        // R2
        {4'd3,  1'b1, 12'h018, 32'h80000000, 32'h0},        // R3 staged
        {4'd3,  1'b0, 12'h018, 32'h0, 32'h0},               // R3
        {4'd3,  1'b0, 12'h01C, 32'h0, 32'h0},               // R3
        {4'd3,  1'b1, 12'h01C, 32'h00000001, 32'h0},        // R3 commit
        {4'd3,  1'b0, 12'h018, 32'h0, 32'h0},               // R3 carry out of low
        {4'd3,  1'b0, 12'h01C, 32'h0, 32'h00000003},        // R3
        {4'd3,  1'b1, 12'h018, 32'hFFFFFFFF, 32'h0},        // R3
        {4'd3,  1'b1, 12'h01C, 32'hFFFFFFFF, 32'h0},        // R3
        {4'd3,  1'b0, 12'h018, 32'h0, 32'hFFFFFFFE},        // R3 wrap
        {4'd3,  1'b0, 12'h01C, 32'h0, 32'hFFFFFFFF},        // R3
        {4'd5,  1'b1, 12'h028, 32'h00001234, 32'h0},        // R5
        {4'd5,  1'b1, 12'h02C, 32'hAABBCCDD, 32'h0},        // R5
        {4'd5,  1'b0, 12'h028, 32'h0, 32'h00001234},        // R5
        {4'd5,  1'b0, 12'h02C, 32'h0, 32'hAABBCCDD},        // R5
        {4'd5,  1'b1, 12'h030, 32'd7, 32'h0},               // R5
        {4'd5,  1'b0, 12'h030, 32'h0, 32'd7},               // R5
        {4'd10, 1'b1, 12'h03C, 32'h5555, 32'h0},            // R10
        {4'd10, 1'b0, 12'h03C, 32'h0, 32'h0},               // R10
        {4'd10, 1'b0, 12'h024, 32'h0, 32'h0},               // R10
        {4'd10, 1'b0, 12'h038, 32'h0, 32'h0},               // R10
        {4'd10, 1'b0, 12'h014, 32'h0, 32'h0},               // R10
        {4'd10, 1'b0, 12'h040, 32'h0, 32'h0}                // R10
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rsp_rdata;
        v = rsp_valid;
    endtask

    task automatic wait_idle();
        logic [31:0] d;
        logic        v;
        for (int k = 0; k < 300; k++) begin
            rd(12'h034, d, v);
            if (!d[31]) break;
        end
    endtask

    initial begin
        #(10 * 100000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic        v;
        int          c0;
        logic        ok;

        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        chk("R11 irq_valid after reset", 32'(irq_valid), 32'd0);
        chk("R11 mem_valid after reset", 32'(mem_valid), 32'd0);
        rst_n = 1'b1;
        rd(12'h034, d, v);
        chk("R9 control after reset", d, 32'h0);
        chk("R11 rsp_valid one cycle after read", 32'(v), 32'd1);
        @(negedge clk);
        chk("R11 rsp_valid drops", 32'(rsp_valid), 32'd0);

        // table walk
        for (int i = 0; i < N_ROWS; i++) begin
            logic [80:0] e;
            e = ROWS[i];
            if (e[76]) begin
                wr(e[75:64], e[63:32]);
            end else begin
                rd(e[75:64], d, v);
                chk($sformatf("R%0d row %0d", e[80:77], i), d, e[31:0]);
            end
        end

        // R4: interrupt pulse
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h020; req_wdata = 32'h000001A5;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk("R4 irq pulse", {23'd0, irq_valid, irq_vec}, {23'd0, 1'b1, 8'hA5});
        @(negedge clk);
        chk("R4 irq one cycle only", 32'(irq_valid), 32'd0);
        rd(12'h020, d, v);
        chk("R4 vector readback", d, 32'h000000A5);

        // R6 R7: fill an unaligned 8-byte buffer
        wr(12'h028, 32'h13); wr(12'h02C, 32'h0); wr(12'h030, 32'd8);
        c0 = acc_cnt;
        wr(12'h034, 32'd2);
        wait_idle();
        ok = 1'b1;
        for (int i = 8'h13; i < 8'h1B; i++) if (mem[i] !== 8'h96) ok = 1'b0;
        chk("R6 fill bytes", 32'(ok), 32'd1);
        chk("R7 neighbours intact", {mem[8'h12], mem[8'h1B]}, {8'h12, 8'h1B});
        chk("R7 fill access count", 32'(acc_cnt - c0), 32'd8);

        // R6 R7: invert the same buffer
        c0 = acc_cnt;
        wr(12'h034, 32'd4);
        wait_idle();
        ok = 1'b1;
        for (int i = 8'h13; i < 8'h1B; i++) if (mem[i] !== 8'h69) ok = 1'b0;
        chk("R6 invert bytes", 32'(ok), 32'd1);
        chk("R7 invert access count", 32'(acc_cnt - c0), 32'd16);

        // R6: clear
        c0 = acc_cnt;
        wr(12'h034, 32'd1);
        wait_idle();
        ok = 1'b1;
        for (int i = 8'h13; i < 8'h1B; i++) if (mem[i] !== 8'h00) ok = 1'b0;
        chk("R6 clear bytes", 32'(ok), 32'd1);
        chk("R7 neighbours after clear", {mem[8'h12], mem[8'h1B]}, {8'h12, 8'h1B});

        // R6: unsupported code starts nothing
        c0 = acc_cnt;
        wr(12'h034, 32'd3);
        repeat (4) @(negedge clk);
        chk("R6 bad code no access", 32'(acc_cnt - c0), 32'd0);
        rd(12'h034, d, v);
        chk("R6 bad code leaves control", d, 32'd1);

        // R8: size zero
        wr(12'h030, 32'd0);
        c0 = acc_cnt;
        wr(12'h034, 32'd2);
        rd(12'h034, d, v);
        chk("R8 size zero done at once", d, 32'd2);
        repeat (4) @(negedge clk);
        chk("R8 size zero no access", 32'(acc_cnt - c0), 32'd0);

        // R9: control write while busy, overlapped with echo and interrupt
        wr(12'h028, 32'h40); wr(12'h030, 32'd16);
        c0 = acc_cnt;
        wr(12'h034, 32'd2);
        wr(12'h034, 32'd1);
        rd(12'h034, d, v);
        chk("R9 busy with fill code", d, 32'h80000002);
        wr(12'h010, 32'd21);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h020; req_wdata = 32'h3C;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk("R4 irq during engine run", {23'd0, irq_valid, irq_vec}, {23'd0, 1'b1, 8'h3C});
        rd(12'h010, d, v);
        chk("R2 echo during engine run", d, 32'd42);
        wait_idle();
        ok = 1'b1;
        for (int i = 8'h40; i < 8'h50; i++) if (mem[i] !== 8'h96) ok = 1'b0;
        chk("R9 ignored clear left fill", 32'(ok), 32'd1);
        chk("R9 access count", 32'(acc_cnt - c0), 32'd16);
        rd(12'h034, d, v);
        chk("R9 idle control", d, 32'd2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule